// File: doc/BRIEF.md
# Scheduled Tile Crossbar Switch

This block is the static routing switch of one tile in a mesh of identical tiles. It moves data words between five ports: four neighbours (north, east, south, west) and the tile's own processor. It does not decode packet headers. Instead it follows a route schedule stored in a small private program memory. A dedicated program counter steps through that memory, separate from the processor's. Each program word gives, for every output, the input it takes its word from in that step. Each word also carries a sequencing operation that can jump or repeat a span of the schedule a set number of times.

One program word is a single routing step. All of its routes move in the same cycle, or none of them do. If a named source has no word, or a named destination is not ready, the whole schedule freezes in place. Nothing is dropped and nothing is reordered. An output that the current step leaves unused is handed to the dynamic network for that cycle. While the switch is halted, software may write a new program, and the new program is the new schedule.

Top module: `static_route_switch`

## Requirements
- R1: After reset the schedule counter is at address 0, and no static transfer takes place. While `run` is low, every output carries only dynamic traffic.
- R2: Port index p (north=0, east=1, south=2, west=3, processor=4) selects the slice [W*p+W-1:W*p] of each data bus. In a program word, bits [3o+2:3o] hold the source select for output o. Values 0 to 4 name that input. Values 5 to 7 mean no route. When a word retires, each routed output presents the selected input's data with `out_valid` high.
- R3: A word retires only in a cycle where every routed output is ready and every selected input is valid. In any other cycle no routed output shows valid, no input is consumed, and the counter holds.
- R4: One input may feed several outputs in the same word. That input's `in_ready` is high only in the cycle when all of those outputs take the word, and all of them receive the same data.
- R5: Program bits [16:15] hold the operation. When the operation is 0 or 3 and the word retires, the counter advances by one and wraps from DEPTH-1 back to 0.
- R6: Operation 1 (jump) sends the counter to the target held in bits [20:17] when the word retires.
- R7: Operation 2 (loop) carries a count K in bits [24:21]. On successive retirements it jumps to the target K times and then falls through to the next address. K=0 always falls through. Only one loop can be active at a time.
- R8: An output with no route in the current word (or any output while the switch is halted or being cleared) follows the dynamic channel: `out_valid`=`dyn_valid`, `out_data`=`dyn_data`, and `dyn_ready`=`out_ready`. A routed output always shows `dyn_ready` low, even when its step is stalled.
- R9: A program write is taken only while `run` is low. The word goes to `prog_addr`. A write while `run` is high has no effect.
- R10: While `run` is low the counter holds and no static transfer occurs. A cycle with `pc_clear` high moves no static word, sends the counter to 0, and ends any active loop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | High: execute the schedule; low: halted, program writes allowed |
| pc_clear | input | 1 | Send the counter to 0 and end any active loop |
| prog_we | input | 1 | Program write strobe |
| prog_addr | input | AW | Program write address |
| prog_data | input | IW | Program word |
| in_data | input | 5*W | Input words, one slice per port |
| in_valid | input | 5 | Input word present, per port |
| in_ready | output | 5 | Input word consumed this cycle, per port |
| out_data | output | 5*W | Output words, one slice per port |
| out_valid | output | 5 | Output word present, per port |
| out_ready | input | 5 | Output destination accepts, per port (must not depend on out_valid) |
| dyn_data | input | 5*W | Dynamic network words offered per output |
| dyn_valid | input | 5 | Dynamic word offered per output |
| dyn_ready | output | 5 | Dynamic word taken per output |

## Verification
The hardest case to reach from the ports is the loop operation. A loop repeat only happens after several retirements, and back-pressure interrupts the span between them. Its counter state must survive stalls, clears and the re-entry into the loop. The stimulus loads programs that put self-loops, loops with a count of zero and loops ending in backward jumps into one schedule. It then runs them under heavy random valid and ready patterns, so that stalls land at every position inside each loop. A cycle-level model in the bench tracks the expected counter from these rules, so a wrong step shows up as a wrong output pattern in the cycles that follow.

// File: rtl/srs_pkg.sv
`timescale 1ns/1ps
package srs_pkg;
  localparam int NPORT = 5;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    OP_NEXT  = 2'd0,
    OP_JUMP  = 2'd1,
    OP_LOOP  = 2'd2,
    OP_SPARE = 2'd3
  } op_e;
endpackage

// File: rtl/srs_imem.sv
`timescale 1ns/1ps
module srs_imem #(
  parameter int IW    = 25,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [IW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [IW-1:0] rdata
);
  logic [IW-1:0] mem_q [DEPTH];

  // Storage array: no reset; every entry has its own write enable.
  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      if (we && (waddr == AW'(e))) begin
        mem_q[e] <= wdata;
      end
    end
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/srs_seq.sv
`timescale 1ns/1ps
module srs_seq import srs_pkg::*; #(
  parameter int AW    = 4,
  parameter int CW    = 4,
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  op_e           op,
  input  logic [AW-1:0] target,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] pc
);
  logic [AW-1:0] pc_q, pc_d, pc_inc;
  logic          act_q, act_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          en;

  assign pc_inc = (pc_q == AW'(DEPTH - 1)) ? '0 : pc_q + AW'(1);
  assign en     = clear | step;

  always_comb begin
    pc_d  = pc_q;
    act_d = act_q;
    cnt_d = cnt_q;
    if (clear) begin
      pc_d  = '0;
      act_d = 1'b0;
      cnt_d = '0;
    end else if (step) begin
      case (op)
        OP_JUMP: pc_d = target;
        OP_LOOP: begin
          if (!act_q) begin
            if (count == '0) begin
              pc_d = pc_inc;
            end else begin
              pc_d  = target;
              act_d = 1'b1;
              cnt_d = count - CW'(1);
            end
          end else if (cnt_q == '0) begin
            pc_d  = pc_inc;
            act_d = 1'b0;
          end else begin
            pc_d  = target;
            cnt_d = cnt_q - CW'(1);
          end
        end
        default: pc_d = pc_inc;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q  <= '0;
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (en) begin
      pc_q  <= pc_d;
      act_q <= act_d;
      cnt_q <= cnt_d;
    end
  end

  assign pc = pc_q;
endmodule

// File: rtl/srs_xbar.sv
`timescale 1ns/1ps
module srs_xbar import srs_pkg::*; #(
  parameter int NP = 5,
  parameter int W  = 16
) (
  input  logic              run_en,
  input  logic [NP*SEL_W-1:0] sels,
  input  logic [NP*W-1:0]   in_data,
  input  logic [NP-1:0]     in_valid,
  input  logic [NP-1:0]     out_ready,
  input  logic [NP*W-1:0]   dyn_data,
  input  logic [NP-1:0]     dyn_valid,
  output logic [NP-1:0]     in_ready,
  output logic [NP*W-1:0]   out_data,
  output logic [NP-1:0]     out_valid,
  output logic [NP-1:0]     dyn_ready,
  output logic              fire
);
  logic [NP-1:0]    routed;
  logic [NP-1:0]    route_ok;
  logic [NP*NP-1:0] use_map;

  assign fire = run_en & (&route_ok);

  for (genvar o = 0; o < NP; o++) begin : g_out
    logic [SEL_W-1:0] sel;
    logic             src_v;
    logic [W-1:0]     src_d;
    logic [NP-1:0]    hit;

    assign sel = sels[o*SEL_W +: SEL_W];

    always_comb begin
      src_v = 1'b0;
      src_d = '0;
      hit   = '0;
      for (int i = 0; i < NP; i++) begin
        if (sel == SEL_W'(i)) begin
          src_v  = in_valid[i];
          src_d  = in_data[i*W +: W];
          hit[i] = 1'b1;
        end
      end
    end

    assign routed[o]            = run_en & (|hit);
    assign route_ok[o]          = ~routed[o] | (src_v & out_ready[o]);
    assign use_map[o*NP +: NP]  = routed[o] ? hit : '0;
    assign out_valid[o]         = routed[o] ? fire  : dyn_valid[o];
    assign out_data[o*W +: W]   = routed[o] ? src_d : dyn_data[o*W +: W];
    assign dyn_ready[o]         = ~routed[o] & out_ready[o];
  end

  for (genvar i = 0; i < NP; i++) begin : g_in
    logic used;
    always_comb begin
      used = 1'b0;
      for (int o = 0; o < NP; o++) begin
        used = used | use_map[o*NP + i];
      end
    end
    assign in_ready[i] = fire & used;
  end
endmodule

// File: rtl/static_route_switch.sv
`timescale 1ns/1ps
module static_route_switch import srs_pkg::*; #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  parameter int CW    = 4,
  parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int IW    = NPORT*SEL_W + 2 + AW + CW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                pc_clear,
  input  logic                prog_we,
  input  logic [AW-1:0]       prog_addr,
  input  logic [IW-1:0]       prog_data,
  input  logic [NPORT*W-1:0]  in_data,
  input  logic [NPORT-1:0]    in_valid,
  output logic [NPORT-1:0]    in_ready,
  output logic [NPORT*W-1:0]  out_data,
  output logic [NPORT-1:0]    out_valid,
  input  logic [NPORT-1:0]    out_ready,
  input  logic [NPORT*W-1:0]  dyn_data,
  input  logic [NPORT-1:0]    dyn_valid,
  output logic [NPORT-1:0]    dyn_ready
);
  localparam int NP     = NPORT;
  localparam int SELS_W = NP * SEL_W;
  localparam int OP_LSB = SELS_W;
  localparam int TG_LSB = OP_LSB + 2;
  localparam int CT_LSB = TG_LSB + AW;

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rsync_q;
  logic       srst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  logic [AW-1:0] pc_q;
  logic [IW-1:0] instr;
  logic          fire;
  logic          run_en;
  logic          mem_we;

  assign mem_we = prog_we & ~run;
  assign run_en = run & ~pc_clear & srst_n;

  srs_imem #(.IW(IW), .DEPTH(DEPTH), .AW(AW)) u_imem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (prog_addr),
    .wdata (prog_data),
    .raddr (pc_q),
    .rdata (instr)
  );

  srs_seq #(.AW(AW), .CW(CW), .DEPTH(DEPTH)) u_seq (
    .clk    (clk),
    .rst_n  (srst_n),
    .clear  (pc_clear),
    .step   (fire),
    .op     (op_e'(instr[OP_LSB +: 2])),
    .target (instr[TG_LSB +: AW]),
    .count  (instr[CT_LSB +: CW]),
    .pc     (pc_q)
  );

  srs_xbar #(.NP(NP), .W(W)) u_xbar (
    .run_en    (run_en),
    .sels      (instr[SELS_W-1:0]),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .dyn_data  (dyn_data),
    .dyn_valid (dyn_valid),
    .in_ready  (in_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .dyn_ready (dyn_ready),
    .fire      (fire)
  );
endmodule

// File: rtl/srs_checker.sv
`timescale 1ns/1ps
module srs_checker #(
  parameter int NP = 5,
  parameter int W  = 16,
  parameter int AW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          pc_clear,
  input logic [NP-1:0] in_valid,
  input logic [NP-1:0] in_ready,
  input logic [NP-1:0] out_valid,
  input logic [NP-1:0] dyn_valid,
  input logic [NP-1:0] dyn_ready,
  input logic [NP*W-1:0] out_data,
  input logic [NP*W-1:0] dyn_data,
  input logic [AW-1:0] pc,
  input logic          fire
);
  // R3: a stalled step leaves the schedule counter where it was
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !pc_clear && !fire) |=> $stable(pc));

  // R10: clear returns the counter to zero
  p_clear_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_clear |=> (pc == '0));

  // R10: halted switch keeps its counter
  p_halt_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !pc_clear) |=> $stable(pc));

  // R10: no static step while halted
  p_halt_nofire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !fire);

  for (genvar i = 0; i < NP; i++) begin : g_port
    // R3: a word is consumed only when it is present
    p_ready_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> in_valid[i]);

    // R4: consuming any input means the whole step retired
    p_consume_on_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready[i] |-> fire);

    // R8: an output granted to the dynamic channel mirrors it
    p_dyn_mirror_r8: assert property (@(posedge clk) disable iff (!rst_n)
      dyn_ready[i] |-> (out_valid[i] == dyn_valid[i] &&
                        out_data[i*W +: W] == dyn_data[i*W +: W]));
  end
endmodule

bind static_route_switch srs_checker #(.NP(NP), .W(W), .AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run       (run),
  .pc_clear  (pc_clear),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .dyn_valid (dyn_valid),
  .dyn_ready (dyn_ready),
  .out_data  (out_data),
  .dyn_data  (dyn_data),
  .pc        (pc_q),
  .fire      (fire)
);

// File: tb/static_route_switch_test.sv
`timescale 1ns/1ps
module static_route_switch_test;
  localparam int W = 16, DEPTH = 16, CW = 4, AW = 4, NP = 5;
  localparam int IW = NP*3 + 2 + AW + CW;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rst_n, run, pc_clear, prog_we;
  logic [AW-1:0]    prog_addr;
  logic [IW-1:0]    prog_data;
  logic [NP*W-1:0]  in_data, dyn_data, out_data;
  logic [NP-1:0]    in_valid, in_ready, out_valid, out_ready, dyn_valid, dyn_ready;

  static_route_switch #(.W(W), .DEPTH(DEPTH), .CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .pc_clear(pc_clear),
    .prog_we(prog_we), .prog_addr(prog_addr), .prog_data(prog_data),
    .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .dyn_data(dyn_data), .dyn_valid(dyn_valid), .dyn_ready(dyn_ready)
  );

  int n_chk = 0, n_bad = 0;
  logic [31:0] seed = 32'h1ace_b00c;
  logic [IW-1:0] m_prog [DEPTH];
  int m_pc = 0, m_act = 0, m_cnt = 0;

  task automatic rng(output logic [31:0] r);
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    r = seed;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One clock cycle: drive after the falling edge, compare, then advance the model.
  task automatic cyc(input string ph, input logic r_run, input logic r_clr,
                     input logic r_we, input logic [AW-1:0] r_addr,
                     input logic [IW-1:0] r_data, input logic r_wrand);
    logic [31:0] r;
    logic [IW-1:0] ins;
    logic [NP-1:0] routed, e_ov, e_ir, e_dr;
    logic [NP*W-1:0] e_od;
    logic fire_e, run_en;
    logic [2:0] sel;
    int op, tgt, cnt, inc;
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      rng(r);
      in_valid[p]  = (r[2:0] != 3'd0);
      out_ready[p] = (r[5:3] != 3'd0);
      dyn_valid[p] = r[6];
      in_data[p*W +: W]  = r[23:8];
      dyn_data[p*W +: W] = r[31:16];
    end
    run = r_run; pc_clear = r_clr;
    if (r_wrand) begin
      rng(r); prog_we = 1'b1; prog_addr = r[AW-1:0];
      rng(r); prog_data = r[IW-1:0];
    end else begin
      prog_we = r_we; prog_addr = r_addr; prog_data = r_data;
    end
    #1;
    run_en = run && !pc_clear;
    ins = m_prog[m_pc];
    fire_e = run_en;
    for (int o = 0; o < NP; o++) begin
      sel = ins[o*3 +: 3];
      routed[o] = run_en && (sel < 3'd5);
      if (routed[o] && !(in_valid[sel] && out_ready[o])) fire_e = 1'b0;
    end
    e_ir = '0;
    for (int o = 0; o < NP; o++) begin
      sel = ins[o*3 +: 3];
      if (routed[o]) begin
        e_ov[o] = fire_e;
        e_od[o*W +: W] = in_data[sel*W +: W];
        e_dr[o] = 1'b0;
        if (fire_e) e_ir[sel] = 1'b1;
      end else begin
        e_ov[o] = dyn_valid[o];
        e_od[o*W +: W] = dyn_data[o*W +: W];
        e_dr[o] = out_ready[o];
      end
    end
    for (int o = 0; o < NP; o++) begin
      chk({"R3 out_valid ", ph}, 32'(out_valid[o]), 32'(e_ov[o]));
      if (e_ov[o]) chk({"R2 out_data ", ph}, 32'(out_data[o*W +: W]), 32'(e_od[o*W +: W]));
    end
    chk({"R4 in_ready ", ph}, 32'(in_ready), 32'(e_ir));
    chk({"R8 dyn_ready ", ph}, 32'(dyn_ready), 32'(e_dr));
    // model update
    if (prog_we && !run) m_prog[prog_addr] = prog_data;
    op  = int'(ins[15 +: 2]);
    tgt = int'(ins[17 +: AW]);
    cnt = int'(ins[17+AW +: CW]);
    inc = (m_pc == DEPTH-1) ? 0 : m_pc + 1;
    if (pc_clear) begin
      m_pc = 0; m_act = 0; m_cnt = 0;
    end else if (fire_e) begin
      if (op == 1) m_pc = tgt;
      else if (op == 2) begin
        if (m_act == 0) begin
          if (cnt == 0) m_pc = inc;
          else begin m_pc = tgt; m_act = 1; m_cnt = cnt - 1; end
        end else if (m_cnt == 0) begin
          m_act = 0; m_pc = inc;
        end else begin
          m_cnt = m_cnt - 1; m_pc = tgt;
        end
      end else m_pc = inc;
    end
  endtask

  function automatic logic [IW-1:0] mk(input logic [14:0] sels, input int op,
                                       input int tgt, input int cnt);
    return {CW'(cnt), AW'(tgt), 2'(op), sels};
  endfunction

  task automatic load_prog(input int kind);
    logic [31:0] r;
    logic [IW-1:0] wd;
    for (int a = 0; a < DEPTH; a++) begin
      rng(r);
      case (kind)
        0: wd = mk(r[14:0], (r[17:16] != 2'd0) ? 0 : int'(r[19:18]),
                   int'(r[23:20]), int'(r[25:24]));
        1: wd = mk(r[14:0], (a % 2 == 0) ? 0 : 3, 0, 0);
        2: wd = mk(r[14:0], (a == 7 || a == 15) ? 1 : 0, (a == 7) ? 10 : 2, 0);
        default: begin
          if (a == 4)       wd = mk(r[14:0], 2, 1, 3);
          else if (a == 9)  wd = mk(r[14:0], 2, 9, 2);
          else if (a == 12) wd = mk(r[14:0], 2, 0, 0);
          else if (a == 15) wd = mk(r[14:0], 1, 3, 0);
          else              wd = mk(r[14:0], 0, 0, 0);
        end
      endcase
      cyc("R9 load", 1'b0, 1'b0, 1'b1, AW'(a), wd, 1'b0);
    end
    cyc("R10 clear", 1'b0, 1'b1, 1'b0, '0, '0, 1'b0);
  endtask

  task automatic run_phase(input string ph, input int n, input logic wr, input logic clr);
    logic [31:0] r;
    for (int k = 0; k < n; k++) begin
      rng(r);
      cyc(ph, 1'b1, clr && (r[5:0] == 6'd0), 1'b0, '0, '0, wr && (r[10:8] == 3'd0));
    end
  endtask

  initial begin
    #500000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    string tags [4];
    tags[0] = "R9 random"; tags[1] = "R5 wrap"; tags[2] = "R6 jump"; tags[3] = "R7 loop";
    rst_n = 1'b0; run = 1'b0; pc_clear = 1'b0; prog_we = 1'b0;
    prog_addr = '0; prog_data = '0;
    in_data = '0; dyn_data = '0; in_valid = '0; out_ready = '1; dyn_valid = '0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk("R1 reset out_valid", 32'(out_valid), 32'd0);
      chk("R1 reset in_ready", 32'(in_ready), 32'd0);
    end
    @(negedge clk); rst_n = 1'b1;
    for (int k = 0; k < 4; k++) cyc("R1 idle", 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
    for (int kind = 0; kind < 4; kind++) begin
      load_prog(kind);
      run_phase(tags[kind], 1200, kind == 0, kind == 0 || kind == 3);
      for (int k = 0; k < 100; k++) cyc("R10 halt", 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
      run_phase(tags[kind], 200, 1'b1, 1'b0);
    end
    @(negedge clk); rst_n = 1'b0; run = 1'b0; pc_clear = 1'b0; prog_we = 1'b0;
    m_pc = 0; m_act = 0; m_cnt = 0;
    @(negedge clk); #1;
    chk("R1 reset again", 32'(in_ready), 32'd0);
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) cyc("R1 idle", 1'b0, 1'b0, 1'b0, '0, '0, 1'b0);
    run_phase("R1 restart", 400, 1'b0, 1'b0);
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule